// File: doc/BRIEF.md
# NAND Flash Strobe Timing Generator

This block turns single-cycle bus requests into correctly timed strobes on an 8-bit NAND flash interface. A request names one of four cycle kinds: command latch, address latch, data write or data read. The generator asserts chip enable and waits a set-up time. It then drives the active-low write or read strobe for a programmed low time, followed by a programmed high time. It reports completion with a one-clock done pulse. For a read, the byte on the flash data bus is captured as the read strobe rises and is presented alongside done.

Every phase length comes from a single 32-bit timing word. Each field counts controller clocks, and a field of zero is stretched to one clock. When a request is marked as one that makes the flash busy, the generator waits a programmed number of clocks before it looks at the ready/busy line. It then holds done back until the line reports ready. Requests may be chained back to back. In that case chip enable stays low, and a bus turnaround gap is inserted only where the data direction flips between the write kinds and a read.

Top module: `nand_strobe_gen`

## Requirements
- R1: For command, address and write kinds, `we_n` is low for the clock count in timing bits 3:0, then high for the count in bits 7:4 before `done`.
- R2: For the read kind, `re_n` is low for the count in bits 11:8, then high for the count in bits 15:12 before `done`. The byte on `nand_din` in the last low clock is held on `rd_data` when `done` is high.
- R3: A request accepted while idle pulls `ce_n` low and waits the count in bits 25:24 before the strobe goes low.
- R4: For a request accepted in the `done` clock of the previous one, the strobe goes low at once when both cycles share a direction. When the direction changes (read against any other kind), the gap is the count in bits 18:16.
- R5: For a request with `req_busy` set, the high phase is followed by the count in bits 23:19. Throughout that window `nand_rdy` has no effect, so with `nand_rdy` held high `done` comes exactly one clock after the window ends.
- R6: After the busy window, `done` is asserted in the clock after the first clock edge at which `nand_rdy` is sampled high.
- R7: Any timing field of value zero gives a phase of exactly one clock.
- R8: `ce_n` stays low from acceptance through `done`, and across back-to-back requests. It returns high in the clock after a `done` that has no new request with it.
- R9: `done` lasts one clock. `req_ready` is high only when idle or during `done`, and `we_n` and `re_n` are never low together.
- R10: In reset, `ce_n`, `we_n` and `re_n` are high, `done` is low and `req_ready` is high.
- R11: `req_kind` encodes 0 as command (`cle` high), 1 as address (`ale` high), 2 as data write and 3 as data read. For kinds 0 to 2, `nand_doe` is high and `nand_dout` carries `req_wdata` while the strobe is low. For kind 3, `nand_doe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_cfg | input | 32 | Packed phase lengths in clocks |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_busy | input | 1 | Request makes the flash busy |
| req_wdata | input | 8 | Byte for command, address or write |
| req_ready | output | 1 | Request accepted on this edge if valid |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| nand_dout | output | 8 | Byte driven toward the flash |
| nand_doe | output | 1 | Output enable for `nand_dout` |
| nand_din | input | 8 | Byte from the flash |
| nand_rdy | input | 1 | Flash ready/busy, high when ready |

## Verification
The assertions assume three things about the inputs. `timing_cfg` does not change while a request is in flight. Requests arrive only when `req_ready` is high. `nand_rdy` is low only when the previous request was a busy-generating one. The stimulus follows all three: it rewrites the timing word only while the block is idle, and it raises `req_valid` only in an idle clock or in the `done` clock of a request it is chaining from. It holds `nand_rdy` low only around requests whose release point it controls.

// File: rtl/nstb_pkg.sv
package nstb_pkg;

    // Width of the widest timing field; all phase counters use it.
    localparam int CNT_W      = 5;
    localparam int CFG_W      = 32;
    localparam int NUM_FIELDS = 7;

    // Field indices into the unpacked array.
    localparam int IX_WR_LOW  = 0;
    localparam int IX_WR_HIGH = 1;
    localparam int IX_RD_LOW  = 2;
    localparam int IX_RD_HIGH = 3;
    localparam int IX_TURN    = 4;
    localparam int IX_BUSY    = 5;
    localparam int IX_CE      = 6;

    // Bit positions and widths inside the timing word, by field index.
    localparam int FLD_LSB [NUM_FIELDS] = '{0, 4, 8, 12, 16, 19, 24};
    localparam int FLD_W   [NUM_FIELDS] = '{4, 4, 4, 4, 3, 5, 2};

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CE_SETUP,
        ST_TURN,
        ST_LOW,
        ST_HIGH,
        ST_BUSY_DLY,
        ST_BUSY_WAIT,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [CNT_W-1:0] wr_low;
        logic [CNT_W-1:0] wr_high;
        logic [CNT_W-1:0] rd_low;
        logic [CNT_W-1:0] rd_high;
        logic [CNT_W-1:0] turn;
        logic [CNT_W-1:0] busy_dly;
        logic [CNT_W-1:0] ce_dly;
    } timing_t;

    typedef struct packed {
        op_kind_e kind;
        logic     busy;
    } op_t;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic logic is_read(input op_kind_e k);
        return k == OP_READ;
    endfunction

endpackage

// File: rtl/nstb_cfg_unpack.sv
module nstb_cfg_unpack
    import nstb_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_word,
    output timing_t          tm
);
    logic [CNT_W-1:0] fld [NUM_FIELDS];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        localparam int LSB = FLD_LSB[g];
        localparam int W   = FLD_W[g];
        logic [W-1:0] raw;
        assign raw    = cfg_word[LSB +: W];
        assign fld[g] = at_least_one(CNT_W'(raw));
    end

    assign tm.wr_low   = fld[IX_WR_LOW];
    assign tm.wr_high  = fld[IX_WR_HIGH];
    assign tm.rd_low   = fld[IX_RD_LOW];
    assign tm.rd_high  = fld[IX_RD_HIGH];
    assign tm.turn     = fld[IX_TURN];
    assign tm.busy_dly = fld[IX_BUSY];
    assign tm.ce_dly   = fld[IX_CE];

endmodule

// File: rtl/nstb_phase_timer.sv
module nstb_phase_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

    AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0)); // R7

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nstb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       timing_cfg,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_busy,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ce_n,
    output logic              we_n,
    output logic              re_n,
    output logic              cle,
    output logic              ale,
    output logic [DATA_W-1:0] nand_dout,
    output logic              nand_doe,
    input  logic [DATA_W-1:0] nand_din,
    input  logic              nand_rdy
);
    timing_t          tm;
    state_e           state_q, state_d;
    op_t              op_q;
    op_kind_e         new_kind;
    logic [DATA_W-1:0] wdata_q, rd_q;
    logic             take_req;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] low_len, high_len, new_low_len;
    logic             in_cycle, in_low;

    nstb_cfg_unpack u_unpack (
        .cfg_word (timing_cfg),
        .tm       (tm)
    );

    nstb_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign new_kind    = op_kind_e'(req_kind);
    assign low_len     = is_read(op_q.kind) ? tm.rd_low  : tm.wr_low;
    assign high_len    = is_read(op_q.kind) ? tm.rd_high : tm.wr_high;
    assign new_low_len = is_read(new_kind)  ? tm.rd_low  : tm.wr_low;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(1);
        take_req = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take_req = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = tm.ce_dly;
                    state_d  = ST_CE_SETUP;
                end
            end
            ST_CE_SETUP, ST_TURN: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = low_len;
                    state_d  = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = high_len;
                    state_d  = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    if (op_q.busy) begin
                        tmr_load = 1'b1;
                        tmr_val  = tm.busy_dly;
                        state_d  = ST_BUSY_DLY;
                    end else begin
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_BUSY_DLY: begin
                if (tmr_done) state_d = ST_BUSY_WAIT;
            end
            ST_BUSY_WAIT: begin
                if (nand_rdy) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (req_valid) begin
                    take_req = 1'b1;
                    tmr_load = 1'b1;
                    if (is_read(new_kind) != is_read(op_q.kind)) begin
                        tmr_val = tm.turn;
                        state_d = ST_TURN;
                    end else begin
                        tmr_val = new_low_len;
                        state_d = ST_LOW;
                    end
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '{kind: OP_CMD, busy: 1'b0};
            wdata_q <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_req) begin
                op_q    <= '{kind: new_kind, busy: req_busy};
                wdata_q <= req_wdata;
            end
            if (state_q == ST_LOW && tmr_done && is_read(op_q.kind)) begin
                rd_q <= nand_din;
            end
        end
    end

    assign in_low   = (state_q == ST_LOW);
    assign in_cycle = (state_q == ST_CE_SETUP) || (state_q == ST_TURN) ||
                      (state_q == ST_LOW) || (state_q == ST_HIGH);

    assign req_ready = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign done      = (state_q == ST_DONE);
    assign rd_data   = rd_q;
    assign ce_n      = (state_q == ST_IDLE);
    assign we_n      = !(in_low && !is_read(op_q.kind));
    assign re_n      = !(in_low &&  is_read(op_q.kind));
    assign cle       = in_cycle && (op_q.kind == OP_CMD);
    assign ale       = in_cycle && (op_q.kind == OP_ADDR);
    assign nand_doe  = ((state_q == ST_LOW) || (state_q == ST_HIGH)) && !is_read(op_q.kind);
    assign nand_dout = wdata_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (we_n || re_n)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_QUIET_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (we_n && re_n)); // R9
    AST_CE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !ce_n); // R8
    AST_CE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n) |-> $past(done)); // R8
    AST_RDY_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && op_q.busy) |-> $past(nand_rdy)); // R6

endmodule

// File: tb/nand_strobe_gen_tb.sv
`timescale 1ns/1ps
module nand_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] timing_cfg;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        req_busy;
    logic [7:0]  req_wdata;
    logic        req_ready, done;
    logic [7:0]  rd_data;
    logic        ce_n, we_n, re_n, cle, ale;
    logic [7:0]  nand_dout;
    logic        nand_doe;
    logic [7:0]  nand_din;
    logic        nand_rdy;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // results of the last measured cycle
    int m_pre, m_low, m_post, m_idx;
    bit m_ce_hi, m_both, m_timeout;
    bit m_cle, m_ale, m_doe;
    logic [7:0] m_dout, m_rd;

    always #2.5 clk = ~clk;

    nand_strobe_gen dut_i (
        .clk(clk), .rst(rst), .timing_cfg(timing_cfg),
        .req_valid(req_valid), .req_kind(req_kind), .req_busy(req_busy),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rd_data(rd_data), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
        .cle(cle), .ale(ale), .nand_dout(nand_dout), .nand_doe(nand_doe),
        .nand_din(nand_din), .nand_rdy(nand_rdy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int wl, input int wh, input int rl,
                                           input int rh, input int ta, input int bd,
                                           input int ce);
        logic [31:0] w;
        w = '0;
        w[3:0]   = wl[3:0];
        w[7:4]   = wh[3:0];
        w[11:8]  = rl[3:0];
        w[15:12] = rh[3:0];
        w[18:16] = ta[2:0];
        w[23:19] = bd[4:0];
        w[25:24] = ce[1:0];
        return w;
    endfunction

    // Must be called at a negedge where req_ready is high.
    task automatic drive_req(input int kind, input bit busy, input logic [7:0] data);
        req_kind  = kind[1:0];
        req_busy  = busy;
        req_wdata = data;
        req_valid = 1'b1;
    endtask

    // Samples every negedge after acceptance; returns at the negedge showing done.
    task automatic measure(input bit is_rd, input int release_at);
        logic strobe;
        m_pre = 0; m_low = 0; m_post = 0; m_idx = 0;
        m_ce_hi = 0; m_both = 0; m_timeout = 0;
        for (int i = 1; i <= 3000; i++) begin
            @(negedge clk);
            if (i == 1) req_valid = 1'b0;
            m_idx = i;
            if (done) begin
                m_rd = rd_data;
                return;
            end
            strobe = is_rd ? re_n : we_n;
            if (!we_n && !re_n) m_both = 1;
            if (ce_n) m_ce_hi = 1;
            if (!strobe) begin
                if (m_low == 0) begin
                    m_cle = cle; m_ale = ale; m_doe = nand_doe; m_dout = nand_dout;
                end
                m_low++;
            end else if (m_low == 0) begin
                m_pre++;
            end else begin
                m_post++;
            end
            if (i == release_at) nand_rdy = 1'b1;
        end
        m_timeout = 1;
        chk("R9", "cycle never completed", 0, 1);
    endtask

    task automatic finish_idle();
        @(negedge clk);
        chk("R8", "ce_n after lone done", int'(ce_n), 1);
        chk("R9", "done single pulse", int'(done), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "ce_n in reset", int'(ce_n), 1);
        chk("R10", "we_n in reset", int'(we_n), 1);
        chk("R10", "re_n in reset", int'(re_n), 1);
        chk("R10", "done in reset", int'(done), 0);
        chk("R10", "req_ready in reset", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_write_cmd();
        timing_cfg = mk_cfg(3, 2, 1, 1, 1, 1, 2);
        drive_req(0, 1'b0, 8'hA5);
        measure(1'b0, 0);
        chk("R3", "ce setup clocks", m_pre, 2);
        chk("R1", "we_n low clocks", m_low, 3);
        chk("R1", "we_n high clocks", m_post, 2);
        chk("R11", "cle on command", int'(m_cle), 1);
        chk("R11", "ale on command", int'(m_ale), 0);
        chk("R11", "doe on command", int'(m_doe), 1);
        chk("R11", "dout on command", int'(m_dout), 8'hA5);
        chk("R9", "no double strobe", int'(m_both), 0);
        finish_idle();
    endtask

    task automatic t_write_addr();
        timing_cfg = mk_cfg(1, 4, 2, 2, 1, 1, 1);
        drive_req(1, 1'b0, 8'h3C);
        measure(1'b0, 0);
        chk("R3", "ce setup clocks addr", m_pre, 1);
        chk("R1", "we_n low addr", m_low, 1);
        chk("R1", "we_n high addr", m_post, 4);
        chk("R11", "ale on address", int'(m_ale), 1);
        chk("R11", "cle on address", int'(m_cle), 0);
        chk("R11", "dout on address", int'(m_dout), 8'h3C);
        finish_idle();
    endtask

    task automatic t_field_max();
        timing_cfg = mk_cfg(15, 15, 1, 1, 1, 1, 3);
        drive_req(2, 1'b0, 8'hFF);
        measure(1'b0, 0);
        chk("R3", "ce setup max", m_pre, 3);
        chk("R1", "we_n low max", m_low, 15);
        chk("R1", "we_n high max", m_post, 15);
        chk("R11", "no cle on write", int'(m_cle), 0);
        chk("R11", "no ale on write", int'(m_ale), 0);
        finish_idle();
    endtask

    task automatic t_read();
        timing_cfg = mk_cfg(1, 1, 5, 4, 1, 1, 1);
        nand_din   = 8'h96;
        drive_req(3, 1'b0, 8'h00);
        measure(1'b1, 0);
        chk("R3", "ce setup read", m_pre, 1);
        chk("R2", "re_n low clocks", m_low, 5);
        chk("R2", "re_n high clocks", m_post, 4);
        chk("R2", "captured byte", int'(m_rd), 8'h96);
        chk("R11", "doe low on read", int'(m_doe), 0);
        finish_idle();
    endtask

    task automatic t_zero_fields();
        timing_cfg = 32'h0;
        drive_req(2, 1'b0, 8'h11);
        measure(1'b0, 0);
        chk("R7", "zero ce setup", m_pre, 1);
        chk("R7", "zero we low", m_low, 1);
        chk("R7", "zero we high", m_post, 1);
        finish_idle();
        nand_din = 8'h5A;
        drive_req(3, 1'b0, 8'h00);
        measure(1'b1, 0);
        chk("R7", "zero re low", m_low, 1);
        chk("R7", "zero re high", m_post, 1);
        chk("R2", "captured byte zero cfg", int'(m_rd), 8'h5A);
        finish_idle();
        drive_req(0, 1'b1, 8'h70);
        measure(1'b0, 0);
        chk("R7", "zero busy delay post", m_post, 3);
        finish_idle();
    endtask

    task automatic t_turnaround();
        timing_cfg = mk_cfg(2, 2, 3, 1, 7, 1, 2);
        nand_din   = 8'hC3;
        drive_req(2, 1'b0, 8'h01);
        measure(1'b0, 0);
        chk("R3", "first of chain setup", m_pre, 2);
        drive_req(3, 1'b0, 8'h00);
        measure(1'b1, 0);
        chk("R4", "write to read gap", m_pre, 7);
        chk("R2", "re_n low in chain", m_low, 3);
        chk("R8", "ce held write->read", int'(m_ce_hi), 0);
        drive_req(3, 1'b0, 8'h00);
        measure(1'b1, 0);
        chk("R4", "read to read gap", m_pre, 0);
        chk("R8", "ce held read->read", int'(m_ce_hi), 0);
        drive_req(0, 1'b0, 8'h90);
        measure(1'b0, 0);
        chk("R4", "read to command gap", m_pre, 7);
        chk("R8", "ce held read->cmd", int'(m_ce_hi), 0);
        drive_req(1, 1'b0, 8'h00);
        measure(1'b0, 0);
        chk("R4", "command to address gap", m_pre, 0);
        finish_idle();
    endtask

    task automatic t_busy_ignore();
        nand_rdy   = 1'b1;
        timing_cfg = mk_cfg(1, 2, 1, 1, 1, 20, 1);
        drive_req(0, 1'b1, 8'h60);
        measure(1'b0, 0);
        chk("R5", "busy window with rdy high", m_post, 2 + 20 + 1);
        finish_idle();
        timing_cfg = mk_cfg(1, 3, 1, 1, 1, 31, 1);
        drive_req(0, 1'b1, 8'h10);
        measure(1'b0, 0);
        chk("R5", "busy window max", m_post, 3 + 31 + 1);
        finish_idle();
    endtask

    task automatic t_busy_wait();
        timing_cfg = mk_cfg(1, 2, 1, 1, 1, 3, 1);
        nand_rdy   = 1'b0;
        drive_req(0, 1'b1, 8'h30);
        measure(1'b0, 13);
        chk("R6", "done after ready rises", m_idx, 14);
        chk("R6", "not timed out", int'(m_timeout), 0);
        finish_idle();
        nand_rdy = 1'b1;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_busy = 1'b0;
        req_wdata = '0; timing_cfg = '0; nand_din = '0; nand_rdy = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_cmd();
        t_write_addr();
        t_field_max();
        t_read();
        t_zero_fields();
        t_turnaround();
        t_busy_ignore();
        t_busy_wait();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule